// File: doc/BRIEF.md
# Sparse-Coefficient Constant Multiplier

This block multiplies an 8-bit unsigned sample stream by a stored 8-bit coefficient. The coefficient is restricted to a sparse form, so the product is a sum of shifted copies of the sample. No general multiplier array is needed.

Two coefficient forms are supported, and a load strobe captures the selection together with the coefficient. In binary form the coefficient is a plain 8-bit value with no more than three bits set. Up to three shifted copies of the sample are added with two adders. In signed-digit form the coefficient is given as two terms. Each term carries its own shift, sign and enable, and the represented value is the signed sum of the enabled powers of two. Typical values are 7 = 8-1, 9 = 8+1, 24 = 16+8 and 56 = 64-8.

When the stored coefficient breaks the rule for its form, the block raises a flag and produces zero products until a legal coefficient is loaded. Samples arrive with a valid strobe. Each product leaves one clock later with its own valid strobe.

Top module: `sparse_cmul`

## Requirements
- R1: After reset, out_valid is 0, out_prod is 0 and coef_bad is 0, and the stored coefficient is binary form with value 0, so samples give product 0.
- R2: In binary form (coef_sd_mode=0 at load) with at most three bits of coef_bits set, out_prod = in_sample * coef_bits. This covers the largest legal value 224 (0xE0).
- R3: In binary form, a coef_bits value with four or more bits set makes coef_bad 1 from the cycle after the load, and every product is 0 while it stays loaded.
- R4: In signed-digit form (coef_sd_mode=1 at load), each term field is {enable at bit 4, negative at bit 3, shift at bits 2:0}. The coefficient is the sum of the enabled terms, each ±2^shift. out_prod = in_sample * coefficient. This must work for 7, 9, 24 and 56.
- R5: In signed-digit form, a coefficient below 0 or above 255 (for example -1, 1-8, or 128+128=256) makes coef_bad 1, and every product is 0.
- R6: out_valid equals in_valid delayed by one clock, and out_prod belongs to the sample of the previous cycle. When in_valid is low, out_prod holds its last value.
- R7: A load takes effect for samples that arrive on the cycle after coef_ld. A sample presented in the same cycle as coef_ld uses the previous coefficient.
- R8: Without coef_ld, changes on coef_sd_mode, coef_bits, term_a and term_b have no effect on products or on coef_bad.
- R9: Fields that the selected form does not use are ignored. A disabled term adds nothing whatever its sign and shift, and coef_bits is ignored in signed-digit form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coef_ld | input | 1 | Coefficient load strobe |
| coef_sd_mode | input | 1 | Form selected at load: 0 binary, 1 signed-digit |
| coef_bits | input | 8 | Binary-form coefficient |
| term_a | input | 5 | Signed-digit term A {en, neg, shift[2:0]} |
| term_b | input | 5 | Signed-digit term B {en, neg, shift[2:0]} |
| in_valid | input | 1 | Sample valid |
| in_sample | input | 8 | Unsigned sample |
| out_valid | output | 1 | Product valid |
| out_prod | output | 16 | Registered product |
| coef_bad | output | 1 | Stored coefficient breaks its form's rule |

## Verification
Binary coefficients with one, two and three set bits are each tried, along with samples 0, 1 and 255. These show whether each shifted copy lands at the right weight and whether the full-scale product 255*224 survives without truncation. Signed-digit coefficients are tried with a positive second digit (sums), a negative one (differences) and a single enabled term. These show that subtraction and term enables work independently. Illegal loads in both forms (four set bits, a negative value, 256) are each followed by a legal one. This shows that the flag and the zeroing both set and clear. Same-cycle load-and-sample stimulus and field changes without a strobe separate the old coefficient from the new one.

// File: rtl/sparse_cmul.sv
module sparse_cmul #(
  parameter int SW  = 8,
  parameter int CW  = 8,
  parameter int SHW = 3,
  parameter int PW  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          coef_ld,
  input  logic          coef_sd_mode,
  input  logic [CW-1:0] coef_bits,
  input  logic [SHW+1:0] term_a,
  input  logic [SHW+1:0] term_b,
  input  logic          in_valid,
  input  logic [SW-1:0] in_sample,
  output logic          out_valid,
  output logic [PW-1:0] out_prod,
  output logic          coef_bad
);
  localparam int NT   = 3;
  localparam int MAXB = 3;
  localparam int AW   = PW + 2;
  localparam int MAXC = (1 << CW) - 1;

  logic [NT-1:0]  t_en_q, t_neg_q, t_en_d, t_neg_d;
  logic [SHW-1:0] t_sh_q [NT];
  logic [SHW-1:0] t_sh_d [NT];
  logic           mode_q, bad_d;
  logic [CW-1:0]  coef_bits_q;

  always_comb begin
    int cnt;
    int sval;
    cnt = 0;
    sval = 0;
    t_en_d = '0;
    t_neg_d = '0;
    for (int k = 0; k < NT; k++) t_sh_d[k] = '0;
    if (!coef_sd_mode) begin
      for (int i = 0; i < CW; i++) begin
        if (coef_bits[i]) begin
          for (int k = 0; k < NT; k++)
            if (cnt == k) begin
              t_en_d[k] = 1'b1;
              t_sh_d[k] = SHW'(i);
            end
          cnt = cnt + 1;
        end
      end
      bad_d = (cnt > MAXB);
    end else begin
      t_en_d[0]  = term_a[SHW+1];
      t_neg_d[0] = term_a[SHW];
      t_sh_d[0]  = term_a[SHW-1:0];
      t_en_d[1]  = term_b[SHW+1];
      t_neg_d[1] = term_b[SHW];
      t_sh_d[1]  = term_b[SHW-1:0];
      if (term_a[SHW+1]) sval = term_a[SHW] ? sval - (1 << term_a[SHW-1:0]) : sval + (1 << term_a[SHW-1:0]);
      if (term_b[SHW+1]) sval = term_b[SHW] ? sval - (1 << term_b[SHW-1:0]) : sval + (1 << term_b[SHW-1:0]);
      bad_d = (sval < 0) || (sval > MAXC);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_en_q      <= '0;
      t_neg_q     <= '0;
      for (int k = 0; k < NT; k++) t_sh_q[k] <= '0;
      mode_q      <= 1'b0;
      coef_bad    <= 1'b0;
      coef_bits_q <= '0;
    end else if (coef_ld) begin
      t_en_q      <= t_en_d;
      t_neg_q     <= t_neg_d;
      for (int k = 0; k < NT; k++) t_sh_q[k] <= t_sh_d[k];
      mode_q      <= coef_sd_mode;
      coef_bad    <= bad_d;
      coef_bits_q <= coef_bits;
    end
  end

  logic signed [AW-1:0] part [NT];
  logic signed [AW-1:0] sum;

  for (genvar k = 0; k < NT; k++) begin : g_term
    logic signed [AW-1:0] shifted;
    assign shifted = $signed(AW'(in_sample) << t_sh_q[k]);
    assign part[k] = !t_en_q[k] ? '0 : (t_neg_q[k] ? -shifted : shifted);
  end

  assign sum = part[0] + part[1] + part[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_prod  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_prod <= coef_bad ? '0 : sum[PW-1:0];
    end
  end

  assert_valid_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_no_spurious_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_bad_zeroes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_bad && in_valid) |=> (out_prod == '0));
  assert_bin_product_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !coef_bad && in_valid) |=>
      (out_prod == PW'(PW'($past(in_sample)) * PW'($past(coef_bits_q)))));
  assert_bin_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_ld && !coef_sd_mode) |=> (coef_bad == ($countones($past(coef_bits)) > MAXB)));
  assert_hold_coef_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !coef_ld |=> $stable(coef_bad));
endmodule

// File: tb/sparse_cmul_tb_top.sv
module sparse_cmul_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic coef_ld = 1'b0, coef_sd_mode = 1'b0;
  logic [7:0] coef_bits = '0;
  logic [4:0] term_a = '0, term_b = '0;
  logic in_valid = 1'b0;
  logic [7:0] in_sample = '0;
  logic out_valid, coef_bad;
  logic [15:0] out_prod;

  always #10 clk = ~clk;

  sparse_cmul dut_i (.clk, .rst_n, .coef_ld, .coef_sd_mode, .coef_bits,
    .term_a, .term_b, .in_valid, .in_sample, .out_valid, .out_prod, .coef_bad);

  int checks = 0, fails = 0;
  int exp_q[$];
  string tag_q[$];
  int m_val = 0;
  bit m_bad = 1'b0;
  int last_prod = 0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int term_val(input logic [4:0] t);
    if (!t[4]) return 0;
    return t[3] ? -(1 << t[2:0]) : (1 << t[2:0]);
  endfunction

  task automatic model_load(input logic sdm, input logic [7:0] b,
                            input logic [4:0] ta, input logic [4:0] tb);
    if (!sdm) begin
      m_val = b;
      m_bad = ($countones(b) > 3);
    end else begin
      m_val = term_val(ta) + term_val(tb);
      m_bad = (m_val < 0) || (m_val > 255);
    end
  endtask

  task automatic push(input logic [7:0] s, input string tag);
    exp_q.push_back(m_bad ? 0 : (s * m_val) & 16'hFFFF);
    tag_q.push_back(tag);
  endtask

  task automatic load(input logic sdm, input logic [7:0] b, input logic [4:0] ta,
                      input logic [4:0] tb, input string tag);
    @(negedge clk);
    in_valid = 1'b0;
    coef_ld = 1'b1; coef_sd_mode = sdm; coef_bits = b; term_a = ta; term_b = tb;
    model_load(sdm, b, ta, tb);
    @(negedge clk);
    coef_ld = 1'b0;
    check({tag, " coef_bad"}, int'(coef_bad), int'(m_bad));
  endtask

  task automatic send(input logic [7:0] s, input string tag);
    @(negedge clk);
    coef_ld = 1'b0;
    in_valid = 1'b1; in_sample = s;
    push(s, tag);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check("R6 unexpected out_valid", 1, 0);
      end else begin
        automatic int e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, int'(out_prod), e);
        last_prod = e;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 out_prod", int'(out_prod), 0);
    check("R1 coef_bad", int'(coef_bad), 0);
    send(8'd77, "R1 zero coef product");
    idle(1);

    load(1'b0, 8'hE0, 5'h0, 5'h0, "R2 224");
    send(8'd0, "R2 224*0"); send(8'd1, "R2 224*1");
    send(8'd255, "R2 224*255"); send(8'd100, "R2 224*100");
    load(1'b0, 8'h0B, 5'h0, 5'h0, "R2 11");
    send(8'd255, "R2 11*255"); send(8'd3, "R2 11*3");
    load(1'b0, 8'h01, 5'h0, 5'h0, "R2 1");
    send(8'd200, "R2 1*200");
    load(1'b0, 8'h41, 5'h0, 5'h0, "R2 65");
    send(8'd255, "R2 65*255");
    idle(2);
    check("R6 out_valid low when idle", int'(out_valid), 0);
    check("R6 out_prod holds", int'(out_prod), last_prod);

    load(1'b0, 8'h0F, 5'h0, 5'h0, "R3 four bits");
    send(8'd200, "R3 zero product 0x0F");
    load(1'b0, 8'hFF, 5'h0, 5'h0, "R3 eight bits");
    send(8'd9, "R3 zero product 0xFF");

    load(1'b1, 8'h00, 5'b10011, 5'b11000, "R4 7=8-1");
    send(8'd255, "R4 7*255"); send(8'd10, "R4 7*10");
    load(1'b1, 8'h00, 5'b10011, 5'b10000, "R4 9=8+1");
    send(8'd255, "R4 9*255");
    load(1'b1, 8'h00, 5'b10100, 5'b10011, "R4 24=16+8");
    send(8'd201, "R4 24*201");
    load(1'b1, 8'h00, 5'b10110, 5'b11011, "R4 56=64-8");
    send(8'd255, "R4 56*255"); send(8'd1, "R4 56*1");

    load(1'b1, 8'h00, 5'b10111, 5'b10111, "R5 256");
    send(8'd5, "R5 zero product 256");
    load(1'b1, 8'h00, 5'b10000, 5'b11011, "R5 1-8");
    send(8'd5, "R5 zero product 1-8");
    load(1'b1, 8'h00, 5'b11000, 5'b00000, "R5 -1");
    send(8'd5, "R5 zero product -1");
    load(1'b1, 8'h00, 5'b11111, 5'b11111, "R5 -256");
    send(8'd5, "R5 zero product -256");

    load(1'b1, 8'hFF, 5'b10101, 5'b01111, "R9 disabled term B");
    send(8'd99, "R9 only term A counts");
    load(1'b1, 8'h00, 5'b01111, 5'b01010, "R9 both disabled");
    send(8'd99, "R9 zero coefficient legal");
    load(1'b0, 8'h05, 5'b11111, 5'b11111, "R9 binary ignores terms");
    send(8'd40, "R9 binary 5*40");

    @(negedge clk);
    in_valid = 1'b1; in_sample = 8'd30;
    coef_ld = 1'b1; coef_sd_mode = 1'b0; coef_bits = 8'h30;
    push(8'd30, "R7 same-cycle sample uses old coef");
    model_load(1'b0, 8'h30, 5'h0, 5'h0);
    send(8'd30, "R7 next sample uses new coef");

    send(8'd7, "R8 baseline");
    @(negedge clk);
    coef_sd_mode = 1'b1; coef_bits = 8'hFF; term_a = 5'b11111; term_b = 5'b11111;
    in_valid = 1'b1; in_sample = 8'd11;
    push(8'd11, "R8 fields without strobe ignored");
    idle(1);
    check("R8 coef_bad unchanged", int'(coef_bad), 0);

    idle(3);
    check("R6 scoreboard drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule